// File: doc/BRIEF.md
# Shutter window sequence generator

This block opens and closes an acquisition window that decides when triggers may flow to the devices under test. A sequence begins on one of two kinds of start event. The first is a rising edge on one chosen trigger input out of six. The second is the wrap of a free-running internal period counter. From that start, a single counter steps once per clock. Three programmable delays, all counted from the same start, set three points in the window. The first point raises the shutter. The second lifts the trigger veto. The third drops the shutter and restores the veto.

Software programs the block through a simple register write port. There are six registers: control, source select, period, and the three delays. The delays are copied when a sequence starts, so a write made during a sequence only affects the next one. While the block is enabled and no window is open, the veto stays high, so the trigger logic downstream is held off. A separate line reports that a sequence is running.

Top module: `shutter_window_gen`

## Requirements
- R1: After reset all registers are zero. While control bit 0 (enable) is 0, `shutter_o`, `veto_o` and `seq_active_o` are all low.
- R2: A write with `wr_en` high stores `wr_data` into the register at `wr_addr`, and the new value is in use from the next clock. The addresses are: 0 = control (bit 0 enable, bit 1 source: 0 = external input, 1 = internal period), 1 = source select, 2 = period, 3 = open delay, 4 = release delay, 5 = close delay.
- R3: In external mode, a rising edge on `trig_in[s]`, where s is the source select value 0 to 5, starts a sequence. The edge is taken at the first clock that samples the input high, and the count is 0 in the cycle after that clock. Edges on the other inputs are ignored. Select values 6 and 7 start nothing.
- R4: During a sequence, `shutter_o` is high exactly for counts n with open ≤ n < close.
- R5: While enabled, `veto_o` is low exactly for counts n with release ≤ n < close. It is high at every other time, including when no sequence is running.
- R6: `seq_active_o` is high for counts 0 through close, and low again in the cycle after that.
- R7: If close ≤ open, the shutter never rises. If close ≤ release, the veto never drops.
- R8: A start event that comes while `seq_active_o` is high is ignored. The running count continues and is not restarted.
- R9: In internal mode with period P > 0, start events come every P clocks. The first one is taken P clocks after the enabling write. A start that falls inside a running sequence is skipped. With P = 0 no sequence starts. Trigger inputs have no effect in internal mode.
- R10: The delays are captured at the start of a sequence. A write to them during a sequence changes only later sequences.
- R11: Clearing the enable bit during a sequence ends it. All three outputs are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| trig_in | input | 6 | Synchronous trigger inputs |
| shutter_o | output | 1 | Shutter, high while the window is open |
| veto_o | output | 1 | Trigger veto, low only in the release-to-close part |
| seq_active_o | output | 1 | High while a sequence is running |

## Verification
The main check sweeps every combination of the three delays from 0 to 4. This covers all orderings, ties and zero values. For each combination the bench compares every output against the interval formulas on every count of the sequence, so off-by-one errors at the open, release and close points show up. Two internal-mode runs come next. One uses a period longer than the sequence, which pins the first-start latency and the spacing. The other uses a period shorter than the sequence, which shows that overlapping starts are skipped. Directed sequences cover the rest: a second edge mid-sequence, an edge on a non-selected input, select values that point at no input, a delay write in mid-sequence, and disabling in mid-sequence. These separate restart, selection, snapshot and enable faults.

// File: rtl/shw_pkg.sv
package shw_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] ADR_SRC     = 3'd1;
  localparam logic [REG_AW-1:0] ADR_PERIOD  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_T_OPEN  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_T_REL   = 3'd4;
  localparam logic [REG_AW-1:0] ADR_T_CLOSE = 3'd5;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_INT_BIT = 1;

  typedef enum logic {SRC_EXTERNAL = 1'b0, SRC_INTERNAL = 1'b1} src_mode_e;
endpackage

// File: rtl/shw_regs.sv
module shw_regs
  import shw_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SELW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              ctrl_en,
  output src_mode_e         ctrl_mode,
  output logic [SELW-1:0]   src_sel,
  output logic [DW-1:0]     period,
  output logic [DW-1:0]     t_open,
  output logic [DW-1:0]     t_rel,
  output logic [DW-1:0]     t_close
);
  // Each register is written whole when its address is hit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_mode <= SRC_EXTERNAL;
      src_sel   <= '0;
      period    <= '0;
      t_open    <= '0;
      t_rel     <= '0;
      t_close   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          ctrl_en   <= wr_data[CTRL_EN_BIT];
          ctrl_mode <= src_mode_e'(wr_data[CTRL_INT_BIT]);
        end
        ADR_SRC:     src_sel <= wr_data[SELW-1:0];
        ADR_PERIOD:  period  <= wr_data;
        ADR_T_OPEN:  t_open  <= wr_data;
        ADR_T_REL:   t_rel   <= wr_data;
        ADR_T_CLOSE: t_close <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shw_start.sv
module shw_start
  import shw_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NTRIG = 6,
  parameter int SELW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             ctrl_en,
  input  src_mode_e        ctrl_mode,
  input  logic [SELW-1:0]  src_sel,
  input  logic [DW-1:0]    period,
  output logic             start_req
);
  logic [NTRIG-1:0] trig_q;
  logic [NTRIG-1:0] rise;
  logic             ext_hit;
  logic             int_hit;
  logic             int_run;
  logic [DW-1:0]    pcnt;

  // Decide whether the period counter has reached its last count.
  function automatic logic period_done(input logic [DW-1:0] cnt,
                                       input logic [DW-1:0] per);
    return (per != '0) && (cnt >= per - DW'(1));
  endfunction

  // One edge detector per trigger input.
  generate
    for (genvar g = 0; g < NTRIG; g++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q[g] <= 1'b0;
        else        trig_q[g] <= trig_in[g];
      end
      assign rise[g] = trig_in[g] & ~trig_q[g];
    end
  endgenerate

  // Pick the selected input. Select values outside the input range hit nothing.
  always_comb begin
    ext_hit = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      if (src_sel == SELW'(i)) ext_hit = rise[i];
    end
  end

  assign int_run = ctrl_en && (ctrl_mode == SRC_INTERNAL) && (period != '0);

  // The period counter runs freely while the internal source is active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcnt <= '0;
    else if (!int_run)               pcnt <= '0;
    else if (period_done(pcnt, period)) pcnt <= '0;
    else                             pcnt <= pcnt + DW'(1);
  end

  assign int_hit   = int_run && period_done(pcnt, period);
  assign start_req = ctrl_en && ((ctrl_mode == SRC_EXTERNAL) ? ext_hit : int_hit);
endmodule

// File: rtl/shw_seq.sv
module shw_seq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          start_req,
  input  logic [DW-1:0] t_open,
  input  logic [DW-1:0] t_rel,
  input  logic [DW-1:0] t_close,
  output logic          busy,
  output logic [DW-1:0] cnt,
  output logic          shutter,
  output logic          veto,
  output logic          seq_active
);
  logic [DW-1:0] open_q, rel_q, close_q;
  logic          open_win, go_win;

  // Check whether a count lies in the half-open interval [lo, hi).
  function automatic logic in_span(input logic [DW-1:0] n,
                                   input logic [DW-1:0] lo,
                                   input logic [DW-1:0] hi);
    return (n >= lo) && (n < hi);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      open_q  <= '0;
      rel_q   <= '0;
      close_q <= '0;
    end else if (!ctrl_en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start_req) begin
        busy    <= 1'b1;
        cnt     <= '0;
        open_q  <= t_open;
        rel_q   <= t_rel;
        close_q <= t_close;
      end
    end else if (cnt >= close_q) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + DW'(1);
    end
  end

  assign open_win   = busy && in_span(cnt, open_q, close_q);
  assign go_win     = busy && in_span(cnt, rel_q, close_q);
  assign shutter    = ctrl_en && open_win;
  assign veto       = ctrl_en && !go_win;
  assign seq_active = ctrl_en && busy;
endmodule

// File: rtl/shutter_window_gen.sv
module shutter_window_gen
  import shw_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NTRIG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NTRIG-1:0]  trig_in,
  output logic              shutter_o,
  output logic              veto_o,
  output logic              seq_active_o
);
  localparam int SELW = $clog2(NTRIG + 1);

  logic            ctrl_en;
  src_mode_e       ctrl_mode;
  logic [SELW-1:0] src_sel;
  logic [DW-1:0]   period, t_open, t_rel, t_close;
  logic            start_req;
  logic            seq_busy;
  logic [DW-1:0]   seq_cnt;

  shw_regs #(.DW(DW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .src_sel(src_sel), .period(period),
    .t_open(t_open), .t_rel(t_rel), .t_close(t_close)
  );

  shw_start #(.DW(DW), .NTRIG(NTRIG), .SELW(SELW)) u_start (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ctrl_en(ctrl_en),
    .ctrl_mode(ctrl_mode), .src_sel(src_sel), .period(period), .start_req(start_req)
  );

  shw_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .start_req(start_req),
    .t_open(t_open), .t_rel(t_rel), .t_close(t_close),
    .busy(seq_busy), .cnt(seq_cnt),
    .shutter(shutter_o), .veto(veto_o), .seq_active(seq_active_o)
  );
endmodule

// File: rtl/shw_checker.sv
module shw_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          shutter,
  input logic          veto,
  input logic          active,
  input logic [DW-1:0] cnt
);
  // R1: a disabled block drives all outputs low
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!shutter && !veto && !active));

  // R4: the shutter opens only inside a running sequence
  a_r4_shutter_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> active);

  // R5: the veto lifts only inside a running sequence
  a_r5_release_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !veto) |-> active);

  // R5: once the shutter closes with the block enabled, the veto is back up
  a_r5_close_restores_veto: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shutter) && en) |-> veto);

  // R3: every sequence begins at count zero
  a_r3_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt == '0));

  // R8: a running sequence only ever counts up by one, so it is never restarted
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (cnt == $past(cnt) + DW'(1)));
endmodule

bind shutter_window_gen shw_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .shutter(shutter_o), .veto(veto_o),
  .active(seq_active_o), .cnt(seq_cnt)
);

// File: tb/tb_shutter_window_gen.sv
`timescale 1ns/1ps
module tb_shutter_window_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  trig_in = '0;
  logic        shutter_o, veto_o, seq_active_o;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  shutter_window_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_in(trig_in), .shutter_o(shutter_o), .veto_o(veto_o), .seq_active_o(seq_active_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Raise one input for one cycle. Returns at the negedge where the count is 0.
  task automatic pulse(input int s);
    @(negedge clk); trig_in[s] = 1'b1;
    @(negedge clk); trig_in[s] = 1'b0;
  endtask

  task automatic set_delays(input int o, input int r, input int c);
    wr(3, o); wr(4, r); wr(5, c);
  endtask

  // Expected outputs at count n of a sequence, taken from R4/R5/R6.
  task automatic chk_step(input string ctx, input int n, input int o, input int r, input int c);
    chk($sformatf("R4 shutter %s n=%0d", ctx, n), int'(shutter_o), int'(n >= o && n < c));
    chk($sformatf("R5 veto %s n=%0d", ctx, n), int'(veto_o), int'(!(n >= r && n < c)));
    chk($sformatf("R6 active %s n=%0d", ctx, n), int'(seq_active_o), int'(n <= c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, disabled
    chk("R1 shutter after reset", int'(shutter_o), 0);
    chk("R1 veto after reset", int'(veto_o), 0);
    chk("R1 active after reset", int'(seq_active_o), 0);
    pulse(0);
    chk("R1 disabled ignores edge", int'(seq_active_o), 0);

    // R2: enable in external mode, source 4; idle veto high
    wr(1, 4); wr(0, 1);
    chk("R2 R5 idle veto after enable", int'(veto_o), 1);
    chk("R2 idle shutter", int'(shutter_o), 0);

    // R4 R5 R6 R7: full sweep of delay orderings
    for (int o = 0; o <= 4; o++)
      for (int r = 0; r <= 4; r++)
        for (int c = 0; c <= 4; c++) begin
          set_delays(o, r, c);
          pulse(4);
          for (int n = 0; n <= c + 1; n++) begin
            if (n > 0) @(negedge clk);
            chk_step($sformatf("R7 sweep o=%0d r=%0d c=%0d", o, r, c), n, o, r, c);
          end
        end

    // R3: every select value 0..5 starts from its own input
    set_delays(0, 0, 0);
    for (int s = 0; s < 6; s++) begin
      wr(1, s);
      pulse((s + 1) % 6);
      chk($sformatf("R3 other input sel=%0d", s), int'(seq_active_o), 0);
      pulse(s);
      chk($sformatf("R3 selected input sel=%0d", s), int'(seq_active_o), 1);
      @(negedge clk);
      chk($sformatf("R3 sequence ended sel=%0d", s), int'(seq_active_o), 0);
    end
    // R3: select values 6 and 7 reach no input
    for (int s = 6; s < 8; s++) begin
      wr(1, s);
      @(negedge clk); trig_in = 6'h3f;
      @(negedge clk); trig_in = 6'h00;
      chk($sformatf("R3 out-of-range sel=%0d", s), int'(seq_active_o), 0);
      @(negedge clk);
      chk($sformatf("R3 out-of-range sel=%0d later", s), int'(seq_active_o), 0);
    end

    // R8: a second edge mid-sequence does not restart the count
    wr(1, 2);
    set_delays(1, 2, 8);
    pulse(2);
    for (int n = 0; n <= 11; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 2) trig_in[2] = 1'b1;
      if (n == 3) trig_in[2] = 1'b0;
      chk_step("R8 retrigger", n, 1, 2, 8);
    end

    // R10: a delay write mid-sequence applies only to the next sequence
    set_delays(1, 2, 6);
    pulse(2);
    for (int n = 0; n <= 7; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 1) begin wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'd2; end
      if (n == 2) wr_en = 1'b0;
      chk_step("R10 snapshot first", n, 1, 2, 6);
    end
    pulse(2);
    for (int n = 0; n <= 3; n++) begin
      if (n > 0) @(negedge clk);
      chk_step("R10 snapshot next", n, 1, 2, 2);
    end

    // R11: disabling mid-sequence ends it
    set_delays(0, 0, 20);
    pulse(2);
    repeat (2) @(negedge clk);
    chk("R11 open before disable", int'(shutter_o), 1);
    wr(0, 0);
    chk("R11 shutter after disable", int'(shutter_o), 0);
    chk("R11 veto after disable", int'(veto_o), 0);
    chk("R11 active after disable", int'(seq_active_o), 0);

    // R9: internal mode, period 10, longer than the sequence
    set_delays(1, 2, 3);
    wr(2, 10);
    wr(0, 3);
    for (int m = 1; m <= 40; m++) begin
      @(negedge clk);
      if (m == 5) trig_in[2] = 1'b1;
      if (m == 6) trig_in[2] = 1'b0;
      chk($sformatf("R9 internal P=10 m=%0d", m), int'(seq_active_o),
          int'(m >= 10 && (m % 10) <= 3));
    end

    // R9: period 3, shorter than the sequence; overlapping starts skipped
    wr(0, 0);
    set_delays(0, 0, 4);
    wr(2, 3);
    wr(0, 3);
    for (int m = 1; m <= 30; m++) begin
      @(negedge clk);
      chk($sformatf("R9 skip P=3 m=%0d", m), int'(seq_active_o),
          int'(m >= 3 && ((m - 3) % 6) <= 4));
    end

    // R9: period zero starts nothing, trigger inputs still ignored
    wr(0, 0);
    wr(2, 0);
    wr(0, 3);
    for (int m = 1; m <= 12; m++) begin
      @(negedge clk);
      trig_in = (m % 2 == 1) ? 6'h3f : 6'h00;
      chk($sformatf("R9 period zero m=%0d", m), int'(seq_active_o), 0);
    end
    trig_in = '0;
    chk("R9 period zero veto held", int'(veto_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule